// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block is a register-mapped general-purpose I/O controller. It serves 64 pins, arranged as four banks of sixteen. Each pin can be an input or an output, and each pin can be handed to an alternate function. Every pin can also act as an interrupt source. Software configures the block through a 16-bit register port. The block drives the pad-side output data, output enables and alternate-function selects. It samples the pad inputs through a two-flop synchroniser.

Each pin has its own interrupt detector. The detector can be set to edge mode (rising or falling) or to level mode (active-high or active-low). An event that is not masked latches a pending bit in the bank's status register. Software clears that register by writing zeros to it. A top-level status word gathers one summary bit per bank, together with six external peripheral interrupt inputs. A per-source enable and a global enable then gate the single host interrupt line. The host consumes that line as a rising-edge interrupt.

Top module: `gpio_bank_irq`

## Requirements
- R1: After synchronous reset, pin_oe, pin_out, pin_alt and host_irq are all zero. Every bank's mask register reads 0xFFFF (all pins blocked). The top-level enable register reads 0x0000.
- R2: Pin n belongs to bank n>>4, at bit n&15. A bank's direction register (index 0) drives pin_oe, where 1 means output. Its output register (index 1) drives pin_out. Its alternate-select register (index 3) drives pin_alt. Each of these reads back the value written.
- R3: The input register (index 2) returns the pin levels after a two-flop synchroniser. A value is readable two clocks after it reaches the pins. Writes to this register are ignored.
- R4: In edge mode (trigger register, index 5, bit = 1), an edge-polarity bit (index 6) of 1 latches on a rising synchronised transition, and 0 latches on a falling one. The opposite transition latches nothing, and a held level latches only once.
- R5: In level mode (trigger bit = 0), a level-polarity bit (index 7) of 1 treats high as active, and 0 treats low as active. The pending bit is set again on every cycle the level stays active.
- R6: A mask bit (index 4) of 1 stops that pin from ever setting its pending bit. A mask bit of 0 lets the pin's events through.
- R7: Writing data D to the pending register (index 8) clears each pending bit whose bit in D is 0. Writing 0 therefore clears the whole bank.
- R8: When a new event and a clearing write to the pending register fall in the same cycle, the event wins and its bit stays set.
- R9: The status word (address 0x40) is read-only. Bit b (0 to 3) is set when bank b has a pending bit whose mask bit is 0. Bits 4 to 9 show ext_irq[5:0], registered once. Writes to this address are ignored.
- R10: host_irq is registered. It is 1 only when bit 15 of the enable register (address 0x41) is set and at least one status bit is set together with its enable bit (bits 0 to 9).
- R11: The register address is 7 bits wide. When addr[6] = 0, bits [5:4] select the bank and bits [3:0] select the register index. reg_rdata updates on the clock edge that takes a read request and holds between reads. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pin_in | input | 64 | Raw pad inputs |
| pin_out | output | 64 | Output data to pads |
| pin_oe | output | 64 | Output enables to pads |
| pin_alt | output | 64 | Alternate-function selects |
| ext_irq | input | 6 | Other peripheral interrupt sources |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The checker watches several rules on every cycle. A pending bit rises only while its mask bit was clear. A pending bit falls only after a register write. The pad-facing outputs and the read data change only after an access. host_irq is never high without the global enable. Only the bench scenarios can show the detection semantics. These are the rising-versus-falling selection, level re-latching through a clear, the exact cycle in which an event beats a clear, and the synchroniser latency. The bench also checks the summary bits and the gating of host_irq against a model of random level, polarity and mask patterns.

// File: rtl/gbi_pkg.sv
package gbi_pkg;
  typedef enum logic [3:0] {
    RG_DIR  = 4'd0,
    RG_DOUT = 4'd1,
    RG_PIN  = 4'd2,
    RG_ALT  = 4'd3,
    RG_MASK = 4'd4,
    RG_TRIG = 4'd5,
    RG_EPOL = 4'd6,
    RG_LPOL = 4'd7,
    RG_PEND = 4'd8
  } gbi_reg_e;

  localparam logic [6:0] TOP_STAT_ADDR = 7'h40;
  localparam logic [6:0] TOP_EN_ADDR   = 7'h41;
endpackage

// File: rtl/gbi_sync.sv
module gbi_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/gbi_bank.sv
module gbi_bank
  import gbi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  gbi_reg_e     reg_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] oe,
  output logic [W-1:0] dout,
  output logic [W-1:0] alt,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] rd_word
);
  logic [W-1:0] trig, epol, lpol;
  logic [W-1:0] pin_s, pin_d;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, ev, keep;

  gbi_sync #(.W(W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_s)
  );

  // previous synchronised sample for edge detection
  always_ff @(posedge clk) begin
    if (rst) pin_d <= '0;
    else     pin_d <= pin_s;
  end

  assign rise     = pin_s & ~pin_d;
  assign fall     = ~pin_s & pin_d;
  assign edge_hit = (epol & rise) | (~epol & fall);
  assign lvl_hit  = ~(pin_s ^ lpol);
  assign ev       = ((trig & edge_hit) | (~trig & lvl_hit)) & ~mask;
  assign keep     = (wr_en && reg_sel == RG_PEND) ? wdata : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= '0;
      dout <= '0;
      alt  <= '0;
      mask <= '1;
      trig <= '0;
      epol <= '0;
      lpol <= '0;
      pend <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel)
          RG_DIR:  oe   <= wdata;
          RG_DOUT: dout <= wdata;
          RG_ALT:  alt  <= wdata;
          RG_MASK: mask <= wdata;
          RG_TRIG: trig <= wdata;
          RG_EPOL: epol <= wdata;
          RG_LPOL: lpol <= wdata;
          default: ;
        endcase
      end
      // new events are OR-ed after the clear so they win
      pend <= (pend & keep) | ev;
    end
  end

  always_comb begin
    case (reg_sel)
      RG_DIR:  rd_word = oe;
      RG_DOUT: rd_word = dout;
      RG_PIN:  rd_word = pin_s;
      RG_ALT:  rd_word = alt;
      RG_MASK: rd_word = mask;
      RG_TRIG: rd_word = trig;
      RG_EPOL: rd_word = epol;
      RG_LPOL: rd_word = lpol;
      RG_PEND: rd_word = pend;
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gbi_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int BANK_W = 16,
  parameter int NEXT   = 6,
  parameter int NPINS  = NBANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_alt,
  input  logic [NEXT-1:0]   ext_irq,
  output logic              host_irq
);
  localparam int BSEL_W = $clog2(NBANKS);
  localparam int NSRC   = NBANKS + NEXT;

  logic [BANK_W-1:0] rd_words [NBANKS];
  logic [NPINS-1:0]  pend_all, mask_all;
  logic [NBANKS-1:0] bank_hit;
  logic [NEXT-1:0]   ext_q;
  logic [NSRC-1:0]   src_en, stat;
  logic              glb_en;
  logic [15:0]       stat_word, en_word;
  gbi_reg_e          reg_sel;
  logic              is_bank;

  assign reg_sel = gbi_reg_e'(reg_addr[3:0]);
  assign is_bank = ~reg_addr[6];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic bank_wr;
    logic [BANK_W-1:0] pend_b, mask_b;

    assign bank_wr = reg_en & reg_we & is_bank &
                     (reg_addr[4 +: BSEL_W] == BSEL_W'(b));

    gbi_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_wr),
      .reg_sel (reg_sel),
      .wdata   (reg_wdata[BANK_W-1:0]),
      .pin_raw (pin_in[b*BANK_W +: BANK_W]),
      .oe      (pin_oe[b*BANK_W +: BANK_W]),
      .dout    (pin_out[b*BANK_W +: BANK_W]),
      .alt     (pin_alt[b*BANK_W +: BANK_W]),
      .pend    (pend_b),
      .mask    (mask_b),
      .rd_word (rd_words[b])
    );

    assign pend_all[b*BANK_W +: BANK_W] = pend_b;
    assign mask_all[b*BANK_W +: BANK_W] = mask_b;
    assign bank_hit[b] = |(pend_b & ~mask_b);
  end

  assign stat = {ext_q, bank_hit};

  always_comb begin
    stat_word = '0;
    stat_word[NSRC-1:0] = stat;
    en_word = '0;
    en_word[NSRC-1:0] = src_en;
    en_word[15] = glb_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q    <= '0;
      src_en   <= '0;
      glb_en   <= 1'b0;
      host_irq <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ext_q <= ext_irq;
      if (reg_en && reg_we && reg_addr == TOP_EN_ADDR) begin
        src_en <= reg_wdata[NSRC-1:0];
        glb_en <= reg_wdata[15];
      end
      host_irq <= glb_en & (|(stat & src_en));
      if (reg_en && !reg_we) begin
        if (is_bank)
          reg_rdata <= rd_words[reg_addr[4 +: BSEL_W]];
        else if (reg_addr == TOP_STAT_ADDR)
          reg_rdata <= stat_word;
        else if (reg_addr == TOP_EN_ADDR)
          reg_rdata <= en_word;
        else
          reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/gbi_checker.sv
module gbi_checker #(
  parameter int NPINS = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_en,
  input logic             reg_we,
  input logic [15:0]      reg_rdata,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_out,
  input logic             host_irq,
  input logic [NPINS-1:0] pend_all,
  input logic [NPINS-1:0] mask_all,
  input logic             glb_en
);
  // R1: reset state of outputs
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && !host_irq));

  // R2: pad outputs only move after a write
  a_r2_pads_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_en && reg_we) |-> ($stable(pin_oe) && $stable(pin_out)));

  // R6: a pending bit rises only where the mask was clear
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (pend_all & ~$past(pend_all) & $past(mask_all)) == '0);

  // R7: pending bits fall only after a write
  a_r7_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_all) & ~pend_all)) |-> $past(reg_en && reg_we));

  // R10: host line needs the global enable
  a_r10_needs_global: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> $past(glb_en));

  // R11: read data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_en && !reg_we) |-> $stable(reg_rdata));
endmodule

bind gpio_bank_irq gbi_checker #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .host_irq  (host_irq),
  .pend_all  (pend_all),
  .mask_all  (mask_all),
  .glb_en    (glb_en)
);

// File: tb/gpio_bank_irq_bench.sv
`timescale 1ns/1ps
module gpio_bank_irq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe, pin_alt;
  logic [5:0]  ext_irq = '0;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_oe = '0, m_out = '0, m_alt = '0;
  logic [15:0] lp [4];
  logic [15:0] mk [4];

  always #2 clk = ~clk;

  gpio_bank_irq u_gpio_bank_irq (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt),
    .ext_irq(ext_irq), .host_irq(host_irq)
  );

  function automatic logic [6:0] ba(input int b, input int r);
    return {1'b0, 2'(b), 4'(r)};
  endfunction

  function automatic logic [15:0] lvl_exp(input logic [15:0] p,
                                          input logic [15:0] pol,
                                          input logic [15:0] m);
    return ~(p ^ pol) & ~m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_1234));
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 oe", pin_oe, '0);
    chk("R1 out", pin_out, '0);
    chk("R1 alt", pin_alt, '0);
    chk("R1 host", {63'b0, host_irq}, 64'd0);
    rd(ba(2, 4), d); chk("R1 mask", {48'b0, d}, 64'hFFFF);
    rd(7'h41, d);    chk("R1 top enable", {48'b0, d}, 64'h0);

    // R2 random config writes
    for (int i = 0; i < 40; i++) begin
      int b, k, r;
      logic [15:0] v;
      b = $urandom % 4; k = $urandom % 3; v = 16'($urandom);
      r = (k == 0) ? 0 : (k == 1) ? 1 : 3;
      wr(ba(b, r), v);
      if (r == 0) m_oe[b*16 +: 16] = v;
      else if (r == 1) m_out[b*16 +: 16] = v;
      else m_alt[b*16 +: 16] = v;
      chk("R2 pin_oe", pin_oe, m_oe);
      chk("R2 pin_out", pin_out, m_out);
      chk("R2 pin_alt", pin_alt, m_alt);
      rd(ba(b, r), d); chk("R2/R11 readback", {48'b0, d}, {48'b0, v});
    end

    // R3 synchronised input readback
    for (int i = 0; i < 8; i++) begin
      pin_in = {$urandom, $urandom};
      idle(3);
      for (int b = 0; b < 4; b++) begin
        rd(ba(b, 2), d); chk("R3 pin read", {48'b0, d}, {48'b0, pin_in[b*16 +: 16]});
      end
    end
    wr(ba(1, 2), ~pin_in[31:16]);
    rd(ba(1, 2), d); chk("R3 write ignored", {48'b0, d}, {48'b0, pin_in[31:16]});

    // R4 edge mode, bank 1 pin 3
    pin_in = '0; idle(4);
    wr(ba(1, 5), 16'h0008); wr(ba(1, 6), 16'h0008);
    wr(ba(1, 8), 16'h0000); wr(ba(1, 4), 16'hFFF7);
    idle(3);
    rd(ba(1, 8), d); chk("R4 no edge no event", {48'b0, d}, 64'h0);
    pin_in[19] = 1'b1; idle(4);
    rd(ba(1, 8), d); chk("R4 rising latched", {48'b0, d}, 64'h0008);
    wr(ba(1, 8), 16'h0000); idle(3);
    rd(ba(1, 8), d); chk("R4 held level latches once", {48'b0, d}, 64'h0);
    pin_in[19] = 1'b0; idle(4);
    rd(ba(1, 8), d); chk("R4 falling ignored in rising mode", {48'b0, d}, 64'h0);
    wr(ba(1, 6), 16'h0000);
    pin_in[19] = 1'b1; idle(4);
    rd(ba(1, 8), d); chk("R4 rising ignored in falling mode", {48'b0, d}, 64'h0);
    pin_in[19] = 1'b0; idle(4);
    rd(ba(1, 8), d); chk("R4 falling latched", {48'b0, d}, 64'h0008);
    wr(ba(1, 4), 16'hFFFF); wr(ba(1, 8), 16'h0000);

    // R5 level mode, bank 2 pin 5
    wr(ba(2, 5), 16'h0000); wr(ba(2, 7), 16'h0020);
    wr(ba(2, 8), 16'h0000); wr(ba(2, 4), 16'hFFDF);
    idle(3);
    rd(ba(2, 8), d); chk("R5 inactive low", {48'b0, d}, 64'h0);
    pin_in[37] = 1'b1; idle(4);
    rd(ba(2, 8), d); chk("R5 active high latched", {48'b0, d}, 64'h0020);
    wr(ba(2, 8), 16'h0000);
    rd(ba(2, 8), d); chk("R5 re-latch after clear", {48'b0, d}, 64'h0020);
    pin_in[37] = 1'b0; idle(4);
    wr(ba(2, 8), 16'h0000);
    rd(ba(2, 8), d); chk("R5 clear after level gone", {48'b0, d}, 64'h0);
    wr(ba(2, 7), 16'h0000); idle(2);
    rd(ba(2, 8), d); chk("R5 active low latched", {48'b0, d}, 64'h0020);
    wr(ba(2, 4), 16'hFFFF); wr(ba(2, 8), 16'h0000);
    rd(ba(2, 8), d); chk("R6 masked level stays clear", {48'b0, d}, 64'h0);

    // R6 masked edge, bank 3 pin 0
    wr(ba(3, 5), 16'h0001); wr(ba(3, 6), 16'h0001); wr(ba(3, 8), 16'h0000);
    pin_in[48] = 1'b1; idle(4);
    rd(ba(3, 8), d); chk("R6 masked edge blocked", {48'b0, d}, 64'h0);
    pin_in[48] = 1'b0;

    // R7 partial clear, bank 0 pins 0..3 rising
    wr(ba(0, 5), 16'h000F); wr(ba(0, 6), 16'h000F);
    wr(ba(0, 8), 16'h0000); wr(ba(0, 4), 16'hFFF0);
    pin_in[3:0] = 4'hF; idle(4);
    rd(ba(0, 8), d); chk("R7 four pending", {48'b0, d}, 64'h000F);
    wr(ba(0, 8), 16'h0005);
    rd(ba(0, 8), d); chk("R7 partial clear", {48'b0, d}, 64'h0005);
    wr(ba(0, 8), 16'h0000);
    rd(ba(0, 8), d); chk("R7 zero clears all", {48'b0, d}, 64'h0);
    pin_in[3:0] = 4'h0; idle(4);

    // R8 event and clear in the same cycle
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = ba(0, 8); reg_wdata = 16'h0000;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    rd(ba(0, 8), d); chk("R8 event beats clear", {48'b0, d}, 64'h0002);

    // R9 status word, R10 host gating
    ext_irq = 6'b101001; idle(2);
    rd(7'h40, d); chk("R9 status", {48'b0, d}, {48'b0, 6'b0, 6'b101001, 4'b0001});
    wr(7'h40, 16'h0000);
    rd(7'h40, d); chk("R9 write ignored", {48'b0, d}, {48'b0, 6'b0, 6'b101001, 4'b0001});
    idle(2); chk("R10 disabled", {63'b0, host_irq}, 64'd0);
    wr(7'h41, 16'h0001); idle(3);
    chk("R10 no global enable", {63'b0, host_irq}, 64'd0);
    wr(7'h41, 16'h8001); idle(3);
    chk("R10 bank source", {63'b0, host_irq}, 64'd1);
    wr(7'h41, 16'h8004); idle(3);
    chk("R10 idle source", {63'b0, host_irq}, 64'd0);
    wr(7'h41, 16'h8010); idle(3);
    chk("R10 ext source", {63'b0, host_irq}, 64'd1);
    rd(7'h41, d); chk("R11 enable readback", {48'b0, d}, 64'h8010);
    rd(7'h7F, d); chk("R11 unmapped", {48'b0, d}, 64'h0);
    ext_irq = '0;
    wr(ba(0, 4), 16'hFFFF); wr(ba(0, 8), 16'h0000);
    wr(7'h41, 16'h800F);

    // R5/R6/R9/R10 random level sweep
    for (int i = 0; i < 30; i++) begin
      logic [3:0] hit;
      for (int b = 0; b < 4; b++) begin
        lp[b] = 16'($urandom); mk[b] = 16'($urandom);
        if (i % 5 == 0) mk[b] = 16'hFFFF;
        wr(ba(b, 4), 16'hFFFF); wr(ba(b, 5), 16'h0000); wr(ba(b, 7), lp[b]);
      end
      pin_in = {$urandom, $urandom}; idle(4);
      for (int b = 0; b < 4; b++) wr(ba(b, 8), 16'h0000);
      for (int b = 0; b < 4; b++) wr(ba(b, 4), mk[b]);
      idle(3);
      hit = '0;
      for (int b = 0; b < 4; b++) begin
        logic [15:0] e;
        e = lvl_exp(pin_in[b*16 +: 16], lp[b], mk[b]);
        hit[b] = |e;
        rd(ba(b, 8), d); chk("R5/R6 random pending", {48'b0, d}, {48'b0, e});
      end
      rd(7'h40, d); chk("R9 random summary", {48'b0, d}, {60'b0, hit});
      idle(2);
      chk("R10 random host", {63'b0, host_irq}, {63'b0, |hit});
    end

    done = 1;
    finish_run();
  end
endmodule